// File: doc/BRIEF.md
# Per-Frame Side Packet Buffer

This block sits on a video packet stream and holds the non-image packets that arrive ahead of a frame. Each packet is a run of symbols framed by start and end markers. The first symbol is the header, and its low nibble carries the packet type. Accepted packets go into a small on-chip store of fixed-size slots. When the frame is released, the block plays its packets back, oldest first, on an output stream that uses the same format and honours valid/ready backpressure.

The store is bounded in two ways. There is a maximum number of packets per frame, and a maximum number of symbols per packet. The header symbol counts toward the symbol limit, and the default limit is 10, which is the size of a control packet. Beats are counted as symbols, whatever number of colour channels a beat carries.

A longer packet is cut off at the limit. A packet that arrives when the store is full pushes out the oldest one. Dropping a frame keeps its packets in the store, so they travel with the next released frame. A parameter decides whether control packets are kept or thrown away on entry.

Top module: `frame_side_buffer`

## Requirements
- R1: After synchronous reset the store is empty, `inReady` is 1, and `outValid` and `relDone` are 0. A release on the empty store produces no output beat.
- R2: On release, every stored packet is emitted in arrival order. `outSop` is set only on each packet's header beat, and `outEop` only on its last stored beat.
- R3: A stored packet holds at most MAX_LEN symbols, header included. Input symbols past that count are discarded, and the replayed packet ends with `outEop` on symbol MAX_LEN.
- R4: At most MAX_PKTS packets are held. A packet that starts while the store is full evicts the oldest stored packet.
- R5: A drop strobe keeps all stored packets. Packets that arrive afterwards join them, under the same count limit and eviction order, and all of them replay on the next release.
- R6: A packet whose header low nibble equals CTRL_TYPE (default 4'hF) is stored when KEEP_CTRL=1. When KEEP_CTRL=0 it is consumed and discarded, and it takes no slot.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData`, `outSop` and `outEop` hold their values.
- R8: `inReady` is 0 during the cycle a release is accepted, for the whole replay, and during the done cycle.
- R9: `relDone` is a single-cycle pulse. It rises in the cycle after the last replayed beat is accepted, or in the cycle after the release strobe when the store is empty. After replay the store is empty.
- R10: A release strobe that coincides with a drop strobe is ignored: no beat is output and no `relDone` pulse follows.
- R11: A release strobe that arrives while a packet is being captured is ignored. The packet is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block accepts an input beat |
| inSop | input | 1 | Input beat is a packet header |
| inEop | input | 1 | Input beat ends the packet |
| inData | input | SYM_W | Input symbol; header low TYPE_W bits give the type |
| relStrobe | input | 1 | Release the frame and replay its packets |
| dropStrobe | input | 1 | Drop the frame; packets carry over |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts an output beat |
| outSop | output | 1 | Output beat is a packet header |
| outEop | output | 1 | Output beat ends the packet |
| outData | output | SYM_W | Output symbol |
| relDone | output | 1 | Replay finished (one-cycle pulse) |

## Verification
Most internal faults show up within a single release. A wrong head or tail pointer, or a bad eviction choice, puts packets out of order or loses a carried-over packet at the first replay after the fault. A wrong stored length or read index puts `outEop` on the wrong beat, or cuts a packet short, on that same replay. A miscounted slot total shows either as a missing packet or as a `relDone` pulse that comes too early or too late. The bench therefore sweeps packet lengths across the truncation boundary and packet counts across the eviction boundary. It compares each replay beat by beat against an arithmetic model, with and without backpressure.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef struct packed {
    logic open;     // start a new slot with the header symbol
    logic wr;       // append a payload symbol to the open slot
    logic rdStart;  // load read pointers from the store head
    logic rdAdv;    // an output beat was accepted
    logic finish;   // replay complete, empty the store
  } fsbStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SKIP,
    ST_PLAY,
    ST_DONE
  } fsbState_t;

endpackage

// File: rtl/fsb_datapath.sv
module fsb_datapath
  import fsb_pkg::*;
#(
  parameter int SYM_W    = 8,
  parameter int MAX_PKTS = 4,
  parameter int MAX_LEN  = 10,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  fsbStrobe_t       stb,
  input  logic [SYM_W-1:0] inData,
  output logic [SYM_W-1:0] outData,
  output logic             outSop,
  output logic             outEop,
  output logic             lastBeat,
  output logic             storeEmpty,
  output logic [CNT_W-1:0] storedCount
);

  localparam int PTR_W  = $clog2(MAX_PKTS);
  localparam int IDX_W  = $clog2(MAX_LEN + 1);
  localparam int SIDX_W = $clog2(MAX_LEN);

  logic [PTR_W-1:0] head, tail, curSlot, rdSlot;
  logic [CNT_W-1:0] count, rdLeft;
  logic [IDX_W-1:0] rdIdx;

  logic [IDX_W-1:0] slotLen [MAX_PKTS];
  logic [SYM_W-1:0] slotRd  [MAX_PKTS];

  logic [IDX_W-1:0] wrLen;
  logic             wrRoom;
  logic             lastSym;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(MAX_PKTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wrLen  = slotLen[curSlot];
  assign wrRoom = wrLen < IDX_W'(MAX_LEN);

  // one storage slot per packet, each with its own length register
  for (genvar s = 0; s < MAX_PKTS; s++) begin : gSlot
    logic [SYM_W-1:0] symQ [MAX_LEN];
    logic [IDX_W-1:0] lenR;

    always_ff @(posedge clk) begin
      if (stb.open && tail == PTR_W'(s)) begin
        symQ[0] <= inData;
        lenR    <= IDX_W'(1);
      end else if (stb.wr && wrRoom && curSlot == PTR_W'(s)) begin
        symQ[wrLen[SIDX_W-1:0]] <= inData;
        lenR                    <= wrLen + 1'b1;
      end
    end

    assign slotLen[s] = lenR;
    assign slotRd[s]  = symQ[rdIdx[SIDX_W-1:0]];
  end

  assign lastSym     = (rdIdx + 1'b1) == slotLen[rdSlot];
  assign lastBeat    = lastSym && (rdLeft == CNT_W'(1));
  assign outData     = slotRd[rdSlot];
  assign outSop      = rdIdx == '0;
  assign outEop      = lastSym;
  assign storeEmpty  = count == '0;
  assign storedCount = count;

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= '0;
      curSlot <= '0;
      count   <= '0;
      rdSlot  <= '0;
      rdIdx   <= '0;
      rdLeft  <= '0;
    end else begin
      if (stb.open) begin
        curSlot <= tail;
        tail    <= nextPtr(tail);
        if (count == CNT_W'(MAX_PKTS)) head <= nextPtr(head);
        else                           count <= count + 1'b1;
      end
      if (stb.rdStart) begin
        rdSlot <= head;
        rdIdx  <= '0;
        rdLeft <= count;
      end else if (stb.rdAdv) begin
        if (lastSym) begin
          rdSlot <= nextPtr(rdSlot);
          rdIdx  <= '0;
          rdLeft <= rdLeft - 1'b1;
        end else begin
          rdIdx <= rdIdx + 1'b1;
        end
      end
      if (stb.finish) begin
        head  <= tail;
        count <= '0;
      end
    end
  end

endmodule

// File: rtl/fsb_control.sv
module fsb_control
  import fsb_pkg::*;
#(
  parameter int TYPE_W    = 4,
  parameter int CTRL_TYPE = 15,
  parameter bit KEEP_CTRL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [TYPE_W-1:0] inType,
  input  logic              relStrobe,
  input  logic              dropStrobe,
  input  logic              outReady,
  input  logic              storeEmpty,
  input  logic              lastBeat,
  output logic              inReady,
  output logic              outValid,
  output logic              relDone,
  output fsbStrobe_t        stb
);

  fsbState_t state, stateNext;
  logic releaseGo, beat, keepIt;

  assign releaseGo = relStrobe && !dropStrobe && (state == ST_IDLE);
  assign inReady   = ((state == ST_IDLE) && !releaseGo) ||
                     (state == ST_CAPT) || (state == ST_SKIP);
  assign beat      = inValid && inReady;
  assign keepIt    = KEEP_CTRL || (inType != TYPE_W'(CTRL_TYPE));
  assign outValid  = state == ST_PLAY;
  assign relDone   = state == ST_DONE;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (releaseGo) begin
          if (storeEmpty) stateNext = ST_DONE;
          else begin
            stb.rdStart = 1'b1;
            stateNext   = ST_PLAY;
          end
        end else if (beat && inSop) begin
          if (keepIt) begin
            stb.open = 1'b1;
            if (!inEop) stateNext = ST_CAPT;
          end else if (!inEop) begin
            stateNext = ST_SKIP;
          end
        end
      end
      ST_CAPT: begin
        if (beat) begin
          stb.wr = 1'b1;
          if (inEop) stateNext = ST_IDLE;
        end
      end
      ST_SKIP: begin
        if (beat && inEop) stateNext = ST_IDLE;
      end
      ST_PLAY: begin
        if (outReady) begin
          stb.rdAdv = 1'b1;
          if (lastBeat) begin
            stb.finish = 1'b1;
            stateNext  = ST_DONE;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/frame_side_buffer.sv
module frame_side_buffer
  import fsb_pkg::*;
#(
  parameter int SYM_W     = 8,
  parameter int TYPE_W    = 4,
  parameter int MAX_PKTS  = 4,
  parameter int MAX_LEN   = 10,
  parameter int CTRL_TYPE = 15,
  parameter bit KEEP_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inSop,
  input  logic             inEop,
  input  logic [SYM_W-1:0] inData,
  input  logic             relStrobe,
  input  logic             dropStrobe,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSop,
  output logic             outEop,
  output logic [SYM_W-1:0] outData,
  output logic             relDone
);

  localparam int CNT_W = $clog2(MAX_PKTS + 1);

  fsbStrobe_t       stb;
  logic             storeEmpty, lastBeat;
  logic [CNT_W-1:0] storedCount;

  fsb_control #(
    .TYPE_W   (TYPE_W),
    .CTRL_TYPE(CTRL_TYPE),
    .KEEP_CTRL(KEEP_CTRL)
  ) uCtl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inSop     (inSop),
    .inEop     (inEop),
    .inType    (inData[TYPE_W-1:0]),
    .relStrobe (relStrobe),
    .dropStrobe(dropStrobe),
    .outReady  (outReady),
    .storeEmpty(storeEmpty),
    .lastBeat  (lastBeat),
    .inReady   (inReady),
    .outValid  (outValid),
    .relDone   (relDone),
    .stb       (stb)
  );

  fsb_datapath #(
    .SYM_W   (SYM_W),
    .MAX_PKTS(MAX_PKTS),
    .MAX_LEN (MAX_LEN)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .inData     (inData),
    .outData    (outData),
    .outSop     (outSop),
    .outEop     (outEop),
    .lastBeat   (lastBeat),
    .storeEmpty (storeEmpty),
    .storedCount(storedCount)
  );

endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int SYM_W    = 8,
  parameter int MAX_PKTS = 4,
  parameter int MAX_LEN  = 10,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic             outSop,
  input logic             outEop,
  input logic [SYM_W-1:0] outData,
  input logic             relDone,
  input logic [CNT_W-1:0] storedCount
);

  localparam int IDX_W = $clog2(MAX_LEN + 1);

  logic [IDX_W-1:0] beatIn;

  always_ff @(posedge clk) begin
    if (rst) beatIn <= '0;
    else if (outValid && outReady) beatIn <= outEop ? '0 : beatIn + 1'b1;
  end

  AST_SOP_AT_START: assert property (@(posedge clk) disable iff (rst)
    (outValid && beatIn == '0) |-> outSop); // R2
  AST_NO_MID_SOP: assert property (@(posedge clk) disable iff (rst)
    (outValid && beatIn != '0) |-> !outSop); // R2
  AST_TRUNC_EOP: assert property (@(posedge clk) disable iff (rst)
    (outValid && beatIn == IDX_W'(MAX_LEN - 1)) |-> outEop); // R3
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
    storedCount <= CNT_W'(MAX_PKTS)); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSop) && $stable(outEop))); // R7
  AST_NO_INTAKE: assert property (@(posedge clk) disable iff (rst)
    (outValid || relDone) |-> !inReady); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    relDone |=> !relDone); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    relDone |-> !outValid); // R9

endmodule

bind frame_side_buffer fsb_checker #(
  .SYM_W   (SYM_W),
  .MAX_PKTS(MAX_PKTS),
  .MAX_LEN (MAX_LEN),
  .CNT_W   (CNT_W)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outSop     (outSop),
  .outEop     (outEop),
  .outData    (outData),
  .relDone    (relDone),
  .storedCount(storedCount)
);

// File: tb/sim_frame_side_buffer.sv
module sim_frame_side_buffer;

  localparam int MAX_PKTS = 4;
  localparam int MAX_LEN  = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, inValid, inSop, inEop, dropS;
  logic [7:0] inData;
  logic [1:0] rel, rdy, inRdy, oValid, oSop, oEop, rDone;
  logic [1:0][7:0] oData;

  int nChk = 0;
  int nFail = 0;

  int         mCnt [2];
  int         mLen [2][MAX_PKTS];
  logic [7:0] mSym [2][MAX_PKTS][16];

  frame_side_buffer #(.MAX_PKTS(MAX_PKTS), .MAX_LEN(MAX_LEN), .KEEP_CTRL(1'b1)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inRdy[0]), .inSop(inSop),
    .inEop(inEop), .inData(inData), .relStrobe(rel[0]), .dropStrobe(dropS),
    .outValid(oValid[0]), .outReady(rdy[0]), .outSop(oSop[0]), .outEop(oEop[0]),
    .outData(oData[0]), .relDone(rDone[0]));

  frame_side_buffer #(.MAX_PKTS(MAX_PKTS), .MAX_LEN(MAX_LEN), .KEEP_CTRL(1'b0)) u1 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inRdy[1]), .inSop(inSop),
    .inEop(inEop), .inData(inData), .relStrobe(rel[1]), .dropStrobe(dropS),
    .outValid(oValid[1]), .outReady(rdy[1]), .outSop(oSop[1]), .outEop(oEop[1]),
    .outData(oData[1]), .relDone(rDone[1]));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  function automatic logic [7:0] sym(input logic [3:0] typ, input int id, input int i);
    if (i == 0) return {id[3:0], typ};
    return 8'(id * 7 + i * 13);
  endfunction

  // reference store: index 0 is the oldest packet
  task automatic mdlPush(input int m, input logic [3:0] typ, input int id, input int len);
    int idx;
    if (m == 1 && typ == 4'hF) return;
    if (mCnt[m] == MAX_PKTS) begin
      for (int k = 0; k < MAX_PKTS - 1; k++) begin
        mLen[m][k] = mLen[m][k+1];
        for (int i = 0; i < 16; i++) mSym[m][k][i] = mSym[m][k+1][i];
      end
      mCnt[m]--;
    end
    idx = mCnt[m];
    mLen[m][idx] = (len < MAX_LEN) ? len : MAX_LEN;
    for (int i = 0; i < mLen[m][idx]; i++) mSym[m][idx][i] = sym(typ, id, i);
    mCnt[m]++;
  endtask

  task automatic sendPkt(input logic [3:0] typ, input int id, input int len);
    mdlPush(0, typ, id, len);
    mdlPush(1, typ, id, len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSop = (i == 0); inEop = (i == len - 1); inData = sym(typ, id, i);
    end
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  task automatic dropFrame();
    @(negedge clk); dropS = 1'b1;
    @(negedge clk); dropS = 1'b0;
  endtask

  // release instance sel, collect the replay and compare with the model
  task automatic releaseChk(input int sel, input int mode, input string req);
    logic [7:0] gS [64];
    bit gSop [64];
    bit gEop [64];
    int n, lastCyc, cyc, en, bad;
    bit stall, holdOk, intakeOk, doneOk, seen;
    logic [7:0] heldD;
    bit heldSop, heldEop;
    n = 0; lastCyc = -1; cyc = 0; stall = 0; holdOk = 1; intakeOk = 1; doneOk = 0; seen = 0;
    heldD = '0; heldSop = 0; heldEop = 0;
    @(negedge clk); rel[sel] = 1'b1;
    #1 chk(inRdy[sel] == 1'b0, "R8", "inReady in release cycle", int'(inRdy[sel]), 0);
    @(negedge clk); rel[sel] = 1'b0;
    while (1) begin
      rdy[sel] = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      #1;
      if (rDone[sel]) begin
        seen = 1; doneOk = (cyc == lastCyc + 1);
        break;
      end
      if (oValid[sel]) begin
        if (inRdy[sel]) intakeOk = 0;
        if (stall && (oData[sel] != heldD || oSop[sel] != heldSop || oEop[sel] != heldEop)) holdOk = 0;
        if (rdy[sel]) begin
          if (n < 64) begin gS[n] = oData[sel]; gSop[n] = oSop[sel]; gEop[n] = oEop[sel]; end
          n++; lastCyc = cyc; stall = 0;
        end else begin
          stall = 1; heldD = oData[sel]; heldSop = oSop[sel]; heldEop = oEop[sel];
        end
      end
      cyc++;
      if (cyc > 600) break;
      @(negedge clk);
    end
    rdy[sel] = 1'b1;
    en = 0; bad = -1;
    for (int p = 0; p < mCnt[sel]; p++) begin
      for (int i = 0; i < mLen[sel][p]; i++) begin
        if (bad < 0 && (en >= n || en >= 64 || gS[en] != mSym[sel][p][i] ||
            gSop[en] != (i == 0) || gEop[en] != (i == mLen[sel][p] - 1))) bad = en;
        en++;
      end
    end
    chk(seen, req, "done pulse seen", int'(seen), 1);
    chk(n == en, req, "replayed beat count", n, en);
    chk(bad < 0, req, "first mismatching beat", bad, -1);
    chk(doneOk, "R9", "done cycle after last beat", cyc, lastCyc + 1);
    chk(intakeOk, "R8", "inReady low during replay", int'(intakeOk), 1);
    if (mode != 0) chk(holdOk, "R7", "outputs held under stall", int'(holdOk), 1);
    mCnt[sel] = 0;
  endtask

  task automatic quietChk(input string req, input int cycles);
    bit quiet;
    quiet = 1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); #1;
      if (oValid[0] || rDone[0]) quiet = 0;
    end
    chk(quiet, req, "no replay after ignored release", int'(quiet), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 0; inSop = 0; inEop = 0; inData = '0;
    rel = '0; rdy = 2'b11; dropS = 0;
    mCnt[0] = 0; mCnt[1] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(inRdy[0] == 1'b1, "R1", "inReady after reset", int'(inRdy[0]), 1);
    chk(oValid[0] == 1'b0, "R1", "outValid after reset", int'(oValid[0]), 0);
    chk(rDone[0] == 1'b0, "R1", "relDone after reset", int'(rDone[0]), 0);
    releaseChk(0, 0, "R1");

    // R3: length sweep across the truncation limit
    for (int L = 1; L <= 12; L++) begin
      sendPkt(4'h1, L, L);
      releaseChk(0, L % 2, "R3");
    end

    // R2: mixed lengths, order and markers, under backpressure
    sendPkt(4'h3, 50, 1);
    sendPkt(4'h3, 51, 7);
    sendPkt(4'h3, 52, 2);
    releaseChk(0, 1, "R2");

    // R4: packet count sweep across the eviction limit
    for (int k = 1; k <= 6; k++) begin
      for (int j = 0; j < k; j++) sendPkt(4'h2, 20 + j + k, 2 + j);
      releaseChk(0, k % 2, "R4");
    end

    // R5: dropped frame carries its packets over
    sendPkt(4'h4, 60, 3); sendPkt(4'h4, 61, 4); sendPkt(4'h4, 62, 5);
    dropFrame();
    sendPkt(4'h4, 63, 2); sendPkt(4'h4, 64, 11); sendPkt(4'h4, 65, 1);
    releaseChk(0, 0, "R5");
    sendPkt(4'h5, 66, 3); sendPkt(4'h5, 67, 2);
    dropFrame();
    dropFrame();
    releaseChk(0, 1, "R5");

    // R10: release together with drop is ignored
    sendPkt(4'h6, 70, 4); sendPkt(4'h6, 71, 3);
    @(negedge clk); rel[0] = 1'b1; dropS = 1'b1;
    #1 chk(inRdy[0] == 1'b1, "R10", "inReady with drop+release", int'(inRdy[0]), 1);
    @(negedge clk); rel[0] = 1'b0; dropS = 1'b0;
    quietChk("R10", 4);
    releaseChk(0, 0, "R10");

    // R11: release during capture is ignored, packet still stored
    mdlPush(0, 4'h7, 80, 5);
    mdlPush(1, 4'h7, 80, 5);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSop = (i == 0); inEop = (i == 4); inData = sym(4'h7, 80, i);
      rel[0] = (i == 2);
    end
    @(negedge clk); inValid = 0; inSop = 0; inEop = 0; rel[0] = 0;
    quietChk("R11", 3);
    releaseChk(0, 0, "R11");

    // R6: control packets kept by u0, discarded by u1
    sendPkt(4'h1, 90, 3);
    sendPkt(4'hF, 91, 10);
    sendPkt(4'h1, 92, 4);
    sendPkt(4'hF, 93, 12);
    releaseChk(0, 0, "R6");
    releaseChk(1, 1, "R6");

    // R9: store empty after replay
    releaseChk(0, 0, "R9");

    summary();
    $finish;
  end

endmodule